// File: doc/BRIEF.md
# In-band synchronisation code decoder

This block recovers frame and line timing for a byte-wide camera stream whose sync is carried inside the data itself rather than on separate wires. It follows the stream for a three-byte marker (all-ones, zero, zero). The byte after the marker is a code byte. It is compared with four programmable code values: frame start, line start, line end and frame end. The decoder keeps a small sequencer that turns the recognised codes into frame-valid and line-valid levels. It qualifies each incoming byte as pixel data or not, and it emits a one-cycle sync-error pulse when the code order breaks the expected pattern.

A mode input selects between this in-band decoding and plain pass-through of two external sync inputs, so the same capture path can serve sensors of either kind. Bytes flow through unchanged. The downstream stage sees `m_valid` only for real pixels.

Back-pressure rules: while enabled, `s_ready` equals `m_ready`, and a byte counts as accepted only in a cycle where `s_valid` and `s_ready` are both high. Marker bytes and code bytes are accepted but never presented, so `m_valid` is low for them. `m_valid` never depends on `m_ready`. While disabled, `s_ready` is high and every byte is dropped.

Top module: `emb_sync_decoder`

## Requirements
- R1: After reset, or while `enable` is low, `frame_valid`, `line_valid`, `sync_err` and `m_valid` are low, `s_ready` is high, and the decoder waits for a frame-start code.
- R2: A marker is the byte sequence 0xFF, 0x00, 0x00, and the next accepted byte is the code byte. In in-band mode the value 0xFF is reserved: it is never presented as a pixel, and neither are marker zeros or code bytes.
- R3: A frame-start code seen while waiting raises `frame_valid` from the cycle after the code byte is accepted.
- R4: Inside a frame, line start raises `line_valid`, line end lowers it and frame end (between lines) lowers `frame_valid`, each from the cycle after the code byte.
- R5: `m_valid` is high, in the same cycle, exactly for accepted-able non-reserved bytes offered while both `frame_valid` and `line_valid` are high; `m_data` always equals `s_data`.
- R6: A line-start code inside a line pulses `sync_err` for one cycle, in the cycle after the code byte, and drops both valids back to waiting for frame start.
- R7: Any other out-of-order code inside an open frame gives the same error and return to waiting: frame end or frame start inside a line, and frame start or line end between lines.
- R8: A code byte that matches none of the four programmed values gives the same error and return to waiting, in any state.
- R9: With `embedded_mode` low and `enable` high, `frame_valid` follows `hw_frame` and `line_valid` follows `hw_line` with no delay, and `m_valid` is `s_valid` qualified by both. No byte value is reserved, and `sync_err` stays low.
- R10: While enabled, `s_ready` equals `m_ready`, and a byte offered while `s_ready` is low does not advance the marker or the sequencer.
- R11: While waiting for frame start, a line-start, line-end or frame-end code is ignored without error.
- R12: A broken marker restarts detection. An 0xFF restarts it at its first byte. Any other byte ends it, and is treated as a pixel when inside a line; only zeros that continue a marker are withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; low clears the timing state |
| embedded_mode | input | 1 | 1 = in-band codes, 0 = external sync pass-through |
| code_frame_start | input | W | Code value marking frame start |
| code_line_start | input | W | Code value marking line start |
| code_line_end | input | W | Code value marking line end |
| code_frame_end | input | W | Code value marking frame end |
| hw_frame | input | 1 | External frame-active level (pass-through mode) |
| hw_line | input | 1 | External line-active level (pass-through mode) |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted when high with s_valid |
| s_data | input | W | Input byte |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | W | Output pixel |
| frame_valid | output | 1 | Frame-active level |
| line_valid | output | 1 | Line-active level |
| sync_err | output | 1 | One-cycle synchronisation error pulse |

## Verification
The hardest situations to reach from the ports are the broken markers: an 0xFF or an 0xFF-0x00 pair inside a line that is not followed by a full marker, and a doubled 0xFF in front of a real marker. The stimulus table places these partial sequences between pixels of an open line and checks that the byte that breaks the marker is still presented as a pixel. Error orderings are reached by first building a legal frame and line with complete markers, then sending the offending code. A stalled marker (`m_ready` low) is then followed by a bare code byte, which shows that refused bytes left no trace.

// File: rtl/emb_sync_pkg.sv
package emb_sync_pkg;
  localparam int N_CODES = 4;

  // Marker progress, advanced once per accepted byte
  typedef enum logic [1:0] {
    PRE_NONE,
    PRE_ONES,
    PRE_ONES_Z,
    PRE_CODE
  } pre_st_e;

  // Frame/line sequencer
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_FRAME,
    SEQ_LINE
  } seq_st_e;

  // Index order is also match priority when two codes are equal
  typedef enum logic [1:0] {
    CODE_FS = 2'd0,
    CODE_LS = 2'd1,
    CODE_LE = 2'd2,
    CODE_FE = 2'd3
  } code_e;
endpackage

// File: rtl/esd_preamble.sv
module esd_preamble
  import emb_sync_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         beat,
  input  logic [W-1:0] data,
  output logic         is_ctrl,
  output logic         code_beat
);
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] ZERO = '0;

  pre_st_e st_q, st_d;

  always_comb begin
    if (st_q == PRE_CODE)                           st_d = PRE_NONE;
    else if (data == ONES)                          st_d = PRE_ONES;
    else if (data == ZERO && st_q == PRE_ONES)      st_d = PRE_ONES_Z;
    else if (data == ZERO && st_q == PRE_ONES_Z)    st_d = PRE_CODE;
    else                                            st_d = PRE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  st_q <= PRE_NONE;
    else if (beat)      st_q <= st_d;
  end

  assign code_beat = (st_q == PRE_CODE);
  assign is_ctrl   = code_beat || (data == ONES) ||
                     (data == ZERO && (st_q == PRE_ONES || st_q == PRE_ONES_Z));
endmodule

// File: rtl/esd_code_match.sv
module esd_code_match
  import emb_sync_pkg::*;
#(
  parameter int W = 8,
  parameter int N = N_CODES
) (
  input  logic [W-1:0]         data,
  input  logic [N*W-1:0]       codes,
  output logic                 hit,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = (data == codes[g*W +: W]);
  end

  // Lowest index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/esd_seq.sv
module esd_seq
  import emb_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       code_fire,
  input  logic       hit,
  input  logic [1:0] idx,
  output logic       fv,
  output logic       lv,
  output logic       err
);
  seq_st_e st_q, st_d;
  logic    err_d;
  code_e   kind;

  assign kind = code_e'(idx);

  always_comb begin
    st_d  = st_q;
    err_d = 1'b0;
    if (code_fire) begin
      if (!hit) begin
        st_d  = SEQ_IDLE;
        err_d = 1'b1;
      end else begin
        unique case (st_q)
          SEQ_IDLE: if (kind == CODE_FS) st_d = SEQ_FRAME;
          SEQ_FRAME: begin
            if (kind == CODE_LS)      st_d = SEQ_LINE;
            else if (kind == CODE_FE) st_d = SEQ_IDLE;
            else begin
              st_d  = SEQ_IDLE;
              err_d = 1'b1;
            end
          end
          SEQ_LINE: begin
            if (kind == CODE_LE) st_d = SEQ_FRAME;
            else begin
              st_d  = SEQ_IDLE;
              err_d = 1'b1;
            end
          end
          default: st_d = SEQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st_q <= SEQ_IDLE;
      err  <= 1'b0;
    end else begin
      st_q <= st_d;
      err  <= err_d;
    end
  end

  assign fv = (st_q != SEQ_IDLE);
  assign lv = (st_q == SEQ_LINE);
endmodule

// File: rtl/emb_sync_decoder.sv
module emb_sync_decoder
  import emb_sync_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         embedded_mode,
  input  logic [W-1:0] code_frame_start,
  input  logic [W-1:0] code_line_start,
  input  logic [W-1:0] code_line_end,
  input  logic [W-1:0] code_frame_end,
  input  logic         hw_frame,
  input  logic         hw_line,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data,
  output logic         frame_valid,
  output logic         line_valid,
  output logic         sync_err
);
  localparam int IW = $clog2(N_CODES);

  logic          inband, clr, beat;
  logic          is_ctrl, code_beat;
  logic          hit;
  logic [IW-1:0] idx;
  logic          fv_q, lv_q, err_q;
  logic [N_CODES*W-1:0] code_vec;

  assign inband   = enable && embedded_mode;
  assign clr      = !inband;
  assign s_ready  = !enable || m_ready;
  assign beat     = inband && s_valid && s_ready;
  assign code_vec = {code_frame_end, code_line_end, code_line_start, code_frame_start};

  esd_preamble #(.W(W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .beat     (beat),
    .data     (s_data),
    .is_ctrl  (is_ctrl),
    .code_beat(code_beat)
  );

  esd_code_match #(.W(W), .N(N_CODES)) u_match (
    .data (s_data),
    .codes(code_vec),
    .hit  (hit),
    .idx  (idx)
  );

  esd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .code_fire(beat && code_beat),
    .hit      (hit),
    .idx      (idx),
    .fv       (fv_q),
    .lv       (lv_q),
    .err      (err_q)
  );

  always_comb begin
    if (embedded_mode) begin
      frame_valid = fv_q;
      line_valid  = lv_q;
      sync_err    = err_q && enable;
      m_valid     = enable && s_valid && fv_q && lv_q && !is_ctrl;
    end else begin
      frame_valid = enable && hw_frame;
      line_valid  = enable && hw_line;
      sync_err    = 1'b0;
      m_valid     = enable && s_valid && hw_frame && hw_line;
    end
  end

  assign m_data = s_data;
endmodule

// File: rtl/emb_sync_decoder_chk.sv
module emb_sync_decoder_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         embedded_mode,
  input logic         s_valid,
  input logic         s_ready,
  input logic [W-1:0] s_data,
  input logic         m_valid,
  input logic         m_ready,
  input logic         frame_valid,
  input logic         line_valid,
  input logic         sync_err
);
  // R5: a presented pixel lies inside an active line of an active frame
  p_pix_in_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (frame_valid && line_valid));

  // R2: the reserved all-ones byte never leaves as a pixel in in-band mode
  p_ones_withheld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (embedded_mode && s_data == {W{1'b1}}) |-> !m_valid);

  // R6: the error is a single-cycle pulse
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !sync_err);

  // R7: an error leaves no frame or line open
  p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (!frame_valid && !line_valid));

  // R4: in-band lines exist only inside frames
  p_line_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (embedded_mode && line_valid) |-> frame_valid);

  // R1: disabling clears the timing levels
  p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!frame_valid && !line_valid && !sync_err));

  // R10: a refused byte leaves the in-band levels untouched
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && embedded_mode && s_valid && !s_ready) |=>
      ($stable(frame_valid) && $stable(line_valid)));
endmodule

bind emb_sync_decoder emb_sync_decoder_chk #(.W(W)) u_chk (.*);

// File: tb/emb_sync_decoder_bench.sv
module emb_sync_decoder_bench;
  localparam int W = 8;
  localparam logic [7:0] C_FS = 8'hAB, C_LS = 8'h80, C_LE = 8'h9D, C_FE = 8'hB6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0, embedded_mode = 1'b1;
  logic         hw_frame = 1'b0, hw_line = 1'b0;
  logic         s_valid = 1'b0, m_ready = 1'b1;
  logic [W-1:0] s_data = '0;
  logic         s_ready, m_valid, frame_valid, line_valid, sync_err;
  logic [W-1:0] m_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  emb_sync_decoder #(.W(W)) u_emb_sync_decoder (
    .clk(clk), .rst_n(rst_n), .enable(enable), .embedded_mode(embedded_mode),
    .code_frame_start(C_FS), .code_line_start(C_LS),
    .code_line_end(C_LE), .code_frame_end(C_FE),
    .hw_frame(hw_frame), .hw_line(hw_line),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .frame_valid(frame_valid), .line_valid(line_valid), .sync_err(sync_err)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd11: return "R11";
      default: return "R12";
    endcase
  endfunction

  // Offer one byte; check the same-cycle pixel qualifier
  task automatic put(input logic [7:0] b, input logic exp_mv, input string req);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = b;
    #5;
    check(req, {7'd0, m_valid}, {7'd0, exp_mv});
    if (exp_mv) check("R5", m_data, b);
  endtask

  // {marker first, byte, m_valid, frame_valid after, line_valid after, sync_err after, tag}
  localparam int NV = 33;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h55, 4'b0000, 4'd1},   // pixel before any frame
    {1'b1, C_FS,  4'b0100, 4'd3},
    {1'b1, C_LS,  4'b0110, 4'd4},
    {1'b0, 8'h12, 4'b1110, 4'd5},
    {1'b0, 8'h00, 4'b1110, 4'd5},   // plain zero is a pixel
    {1'b0, 8'hFF, 4'b0110, 4'd2},
    {1'b0, 8'h34, 4'b1110, 4'd12},  // R12: FF then non-zero
    {1'b0, 8'hFF, 4'b0110, 4'd2},
    {1'b0, 8'h00, 4'b0110, 4'd12},  // R12: marker zero withheld
    {1'b0, 8'h05, 4'b1110, 4'd12},  // R12: breaking byte is a pixel
    {1'b1, C_LE,  4'b0100, 4'd4},
    {1'b0, 8'h77, 4'b0100, 4'd5},   // between lines
    {1'b1, C_LS,  4'b0110, 4'd4},
    {1'b0, 8'h42, 4'b1110, 4'd5},
    {1'b0, 8'hFF, 4'b0110, 4'd12},  // R12: doubled FF before marker
    {1'b1, C_LS,  4'b0001, 4'd6},   // R6: line start inside line
    {1'b0, 8'h42, 4'b0000, 4'd6},
    {1'b1, C_LE,  4'b0000, 4'd11},  // R11: ignored while waiting
    {1'b1, C_FE,  4'b0000, 4'd11},
    {1'b1, C_FS,  4'b0100, 4'd3},
    {1'b1, C_LS,  4'b0110, 4'd4},
    {1'b1, C_FE,  4'b0001, 4'd7},   // R7: frame end inside line
    {1'b1, C_FS,  4'b0100, 4'd3},
    {1'b1, C_LS,  4'b0110, 4'd4},
    {1'b0, 8'h66, 4'b1110, 4'd5},
    {1'b1, C_LE,  4'b0100, 4'd4},
    {1'b1, C_FE,  4'b0000, 4'd4},   // legal frame end
    {1'b1, C_FS,  4'b0100, 4'd3},
    {1'b1, 8'hC3, 4'b0001, 4'd8},   // R8: unknown code
    {1'b1, C_FS,  4'b0100, 4'd3},
    {1'b1, C_FS,  4'b0001, 4'd7},   // R7: frame start inside frame
    {1'b1, C_FS,  4'b0100, 4'd3},
    {1'b1, C_LE,  4'b0001, 4'd7}    // R7: line end between lines
  };

  task automatic marker_then(input logic [7:0] b);
    put(8'hFF, 1'b0, "R2");
    put(8'h00, 1'b0, "R2");
    put(8'h00, 1'b0, "R2");
    put(b, 1'b0, "R2");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    s_valid = 1'b1;
    s_data  = 8'h10;
    repeat (3) @(posedge clk);
    #2;
    check("R1", {7'd0, frame_valid}, 8'd0);
    check("R1", {7'd0, line_valid}, 8'd0);
    check("R1", {7'd0, sync_err}, 8'd0);
    check("R1", {7'd0, m_valid}, 8'd0);
    check("R1", {7'd0, s_ready}, 8'd1);
    @(negedge clk);
    rst_n  = 1'b1;
    enable = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      if (v[16]) begin
        put(8'hFF, 1'b0, "R2");
        put(8'h00, 1'b0, "R2");
        put(8'h00, 1'b0, "R2");
      end
      put(v[15:8], v[7], tag_name(v[3:0]));
      @(posedge clk);
      #2;
      check(tag_name(v[3:0]), {7'd0, frame_valid}, {7'd0, v[6]});
      check(tag_name(v[3:0]), {7'd0, line_valid}, {7'd0, v[5]});
      check(tag_name(v[3:0]), {7'd0, sync_err}, {7'd0, v[4]});
    end

    // R10: refused marker bytes leave no trace
    @(negedge clk);
    m_ready = 1'b0;
    #1;
    check("R10", {7'd0, s_ready}, 8'd0);
    put(8'hFF, 1'b0, "R10");
    put(8'h00, 1'b0, "R10");
    put(8'h00, 1'b0, "R10");
    @(negedge clk);
    m_ready = 1'b1;
    #1;
    check("R10", {7'd0, s_ready}, 8'd1);
    put(C_FS, 1'b0, "R10");
    @(posedge clk);
    #2;
    check("R10", {7'd0, frame_valid}, 8'd0);

    // R1: disable mid-line
    marker_then(C_FS);
    marker_then(C_LS);
    @(posedge clk);
    #2;
    check("R1", {7'd0, line_valid}, 8'd1);
    @(negedge clk);
    enable  = 1'b0;
    m_ready = 1'b0;
    s_data  = 8'h21;
    @(posedge clk);
    #2;
    check("R1", {7'd0, frame_valid}, 8'd0);
    check("R1", {7'd0, line_valid}, 8'd0);
    check("R1", {7'd0, m_valid}, 8'd0);
    check("R1", {7'd0, s_ready}, 8'd1);
    @(negedge clk);
    enable  = 1'b1;
    m_ready = 1'b1;
    put(8'h21, 1'b0, "R1");

    // R9: external sync pass-through
    @(negedge clk);
    embedded_mode = 1'b0;
    hw_frame = 1'b1;
    hw_line  = 1'b0;
    s_data   = 8'hFF;
    #2;
    check("R9", {7'd0, frame_valid}, 8'd1);
    check("R9", {7'd0, line_valid}, 8'd0);
    check("R9", {7'd0, m_valid}, 8'd0);
    hw_line = 1'b1;
    #2;
    check("R9", {7'd0, m_valid}, 8'd1);
    check("R9", m_data, 8'hFF);
    check("R9", {7'd0, sync_err}, 8'd0);
    hw_frame = 1'b0;
    #2;
    check("R9", {7'd0, frame_valid}, 8'd0);
    check("R9", {7'd0, m_valid}, 8'd0);

    @(negedge clk);
    s_valid = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule